// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a flash memory and turns multi-cycle write sequences into operating modes and into requests for a separate program/erase engine. Each write presents a 16-bit address and a 16-bit data word. Most commands must first pass a fixed two-write unlock code. The third write then selects an operation, and later writes supply operands or a final confirm. The decoder holds the read mode that a read path uses to pick its source: the memory array, identification data or the query table. It also holds the configuration register, and it supports a bypass state in which program commands skip the unlock.

Program and erase requests leave as single-cycle pulses. Each pulse carries the captured address, and a program pulse also carries the captured data. Once the engine's busy flag is high, no new request is issued. Any write that does not fit the expected sequence drops all partial progress and forces the read mode back to the array. The program and erase algorithms themselves and the storage array are outside this block.

Top module: `fcd_top`

## Requirements
- R1: After synchronous reset, `mode` is 2'b00 (array), `bypass_on` is 0, both request outputs are 0 and `cfg_reg` is 16'h8000. In this register, bit 15 high selects asynchronous read, bit 14 low leaves bus inversion off and bit 10 low leaves power-down off.
- R2: The program sequence is four writes: AAh to address 0555h, 55h to address 02AAh, A0h to 0555h, then an operand write. One clock after the operand write, `prog_req` pulses with `prog_dual`=0, and `prog_addr_a`/`prog_data_a` hold that write's address and data. Command codes are compared on data bits 7:0, and addresses are compared on all 16 bits.
- R3: Double-word program uses the unlock pair, then 40h at 0555h, then two operand writes. There is a single `prog_req` pulse one clock after the second operand, with `prog_dual`=1. The A outputs hold the first operand and the B outputs hold the second.
- R4: Erase is the unlock pair, 80h at 0555h, a second unlock pair, then a confirm on the sixth write. A confirm of 30h pulses `erase_req` with `erase_bank`=0, and 10h pulses it with `erase_bank`=1. In both cases `erase_addr` is the address of the confirm write.
- R5: F0h returns `mode` to 00. It is accepted either as a lone write or as the third write after an unlock. While `busy` is high it is ignored, and the mode and the sequence state stay unchanged.
- R6: A lone write of 98h to address 0055h sets `mode` to 2'b10 (query).
- R7: The unlock pair followed by 90h at 0555h sets `mode` to 2'b01 (identification). In this mode, read address bits 1:0 select the manufacturer code (00), the device code (01), the protection status (10) or the configuration register (11).
- R8: The unlock pair, then 60h at 0555h, then a write with data 03h loads `cfg_reg` from the full address of that last write.
- R9: The unlock pair followed by 20h at 0555h sets `bypass_on` and `mode` 00. In bypass, A0h followed by one operand (or 40h followed by two operands) issues a program request with no unlock, and bypass stays on. A write of 90h followed by 00h clears bypass.
- R10: Any write that breaks the expected sequence, whether in a partial sequence or in bypass, issues no request, clears bypass, sets `mode` to 00 and restarts decoding. `mode` and `cfg_reg` change only in the clock after a write.
- R11: If `busy` is high on the write that would complete a program or erase, no request is issued and `mode` returns to 00.
- R12: Every request is a one-clock pulse, registered one clock after its completing write. `prog_req` and `erase_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Program/erase engine busy |
| mode | output | 2 | Read mode: 00 array, 01 identification, 10 query |
| bypass_on | output | 1 | Unlock bypass active |
| prog_req | output | 1 | Program request pulse |
| prog_dual | output | 1 | Program request carries two words |
| prog_addr_a | output | 16 | First program address |
| prog_data_a | output | 16 | First program data |
| prog_addr_b | output | 16 | Second program address |
| prog_data_b | output | 16 | Second program data |
| erase_req | output | 1 | Erase request pulse |
| erase_bank | output | 1 | 1 = bank erase, 0 = block erase |
| erase_addr | output | 16 | Erase target address |
| cfg_reg | output | 16 | Configuration register |

## Verification
Some properties are checked by assertions on every cycle:
- requests are pulses that stay mutually exclusive and only follow a write;
- no request follows a write made while busy was high;
- bypass always goes with array mode;
- the mode and the configuration register hold between writes.

Other properties need the bench's scenarios. These include that each legal sequence produces exactly its request with the right captured operands, and that corrupting any single write of a program or erase sequence leaves the decoder in array mode with nothing issued. The bench also checks that F0h is ignored under busy and that bypass programs skip the unlock.

// File: rtl/fcd_pkg.sv
// Shared types and command codes for the flash command sequence decoder.
// Assumes command codes are carried on the low data byte.
package fcd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'b00,
        RM_IDENT = 2'b01,
        RM_QUERY = 2'b10
    } rmode_t;

    typedef enum logic [3:0] {
        S_IDLE, S_UNL1, S_SETUP, S_PGM, S_DW1, S_DW2,
        S_ER_U1, S_ER_U2, S_ER_CF, S_CFG,
        S_BY_IDLE, S_BY_PGM, S_BY_DW1, S_BY_DW2, S_BY_EXIT
    } seq_t;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_PGM, ACT_DW1, ACT_DPGM, ACT_ERB, ACT_ERK, ACT_CFG
    } act_t;

    localparam logic [7:0] C_UNL_A  = 8'hAA;
    localparam logic [7:0] C_UNL_B  = 8'h55;
    localparam logic [7:0] C_RESET  = 8'hF0;
    localparam logic [7:0] C_QUERY  = 8'h98;
    localparam logic [7:0] C_IDENT  = 8'h90;
    localparam logic [7:0] C_CFG    = 8'h60;
    localparam logic [7:0] C_CFGCF  = 8'h03;
    localparam logic [7:0] C_PGM    = 8'hA0;
    localparam logic [7:0] C_DPGM   = 8'h40;
    localparam logic [7:0] C_ERASE  = 8'h80;
    localparam logic [7:0] C_ERBLK  = 8'h30;
    localparam logic [7:0] C_ERBANK = 8'h10;
    localparam logic [7:0] C_BYPASS = 8'h20;
    localparam logic [7:0] C_BYEXIT = 8'h00;

endpackage

// File: rtl/fcd_classify.sv
// Cycle classifier: compares one write's address and code byte against the
// fixed unlock, command and query addresses. Purely combinational.
module fcd_classify #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] ADDR_CMD   = ADDR_W'('h555),
    parameter logic [ADDR_W-1:0] ADDR_UNL_B = ADDR_W'('h2AA),
    parameter logic [ADDR_W-1:0] ADDR_QRY   = ADDR_W'('h55)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code,
    output logic              unl_a,
    output logic              unl_b,
    output logic              at_cmd,
    output logic              query_hit
);
    import fcd_pkg::*;

    // address and code matches for the current write
    always_comb begin
        at_cmd    = (addr == ADDR_CMD);
        unl_a     = at_cmd && (code == C_UNL_A);
        unl_b     = (addr == ADDR_UNL_B) && (code == C_UNL_B);
        query_hit = (addr == ADDR_QRY) && (code == C_QUERY);
    end
endmodule

// File: rtl/fcd_sequencer.sv
// Sequence tracker: walks the unlock/setup/operand/confirm steps, owns the
// read mode and the bypass flag, and names the action completed by each write.
// Assumes wr_en is a single-cycle strobe per write.
module fcd_sequencer (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          busy,
    input  logic [7:0]    code,
    input  logic          unl_a,
    input  logic          unl_b,
    input  logic          at_cmd,
    input  logic          query_hit,
    output fcd_pkg::act_t act,
    output logic [1:0]    mode,
    output logic          bypass_on
);
    import fcd_pkg::*;

    seq_t   state, nxt_state;
    rmode_t cur_mode, nxt_mode;
    logic   nxt_byp;
    logic   bad;

    // next-state, mode and action decode for one write
    always_comb begin
        nxt_state = state;
        nxt_mode  = cur_mode;
        nxt_byp   = bypass_on;
        act       = ACT_NONE;
        bad       = 1'b0;
        if (wr_en) begin
            if ((code == C_RESET) && (state == S_IDLE || state == S_SETUP)) begin
                if (!busy) begin
                    nxt_state = S_IDLE;
                    nxt_mode  = RM_ARRAY;
                end
            end else begin
                case (state)
                    S_IDLE: begin
                        if (unl_a)          nxt_state = S_UNL1;
                        else if (query_hit) nxt_mode  = RM_QUERY;
                        else                bad       = 1'b1;
                    end
                    S_UNL1: begin
                        if (unl_b) nxt_state = S_SETUP;
                        else       bad       = 1'b1;
                    end
                    S_SETUP: begin
                        if (!at_cmd) bad = 1'b1;
                        else case (code)
                            C_IDENT:  begin nxt_mode = RM_IDENT; nxt_state = S_IDLE; end
                            C_BYPASS: begin nxt_byp = 1'b1; nxt_mode = RM_ARRAY; nxt_state = S_BY_IDLE; end
                            C_CFG:    nxt_state = S_CFG;
                            C_ERASE:  nxt_state = S_ER_U1;
                            C_PGM:    nxt_state = S_PGM;
                            C_DPGM:   nxt_state = S_DW1;
                            default:  bad = 1'b1;
                        endcase
                    end
                    S_PGM: begin
                        if (busy) bad = 1'b1;
                        else begin act = ACT_PGM; nxt_state = S_IDLE; nxt_mode = RM_ARRAY; end
                    end
                    S_DW1: begin act = ACT_DW1; nxt_state = S_DW2; end
                    S_DW2: begin
                        if (busy) bad = 1'b1;
                        else begin act = ACT_DPGM; nxt_state = S_IDLE; nxt_mode = RM_ARRAY; end
                    end
                    S_ER_U1: begin
                        if (unl_a) nxt_state = S_ER_U2;
                        else       bad       = 1'b1;
                    end
                    S_ER_U2: begin
                        if (unl_b) nxt_state = S_ER_CF;
                        else       bad       = 1'b1;
                    end
                    S_ER_CF: begin
                        nxt_state = S_IDLE;
                        nxt_mode  = RM_ARRAY;
                        if (!busy && code == C_ERBLK)       act = ACT_ERB;
                        else if (!busy && code == C_ERBANK) act = ACT_ERK;
                        else                                bad = 1'b1;
                    end
                    S_CFG: begin
                        if (code == C_CFGCF) begin act = ACT_CFG; nxt_state = S_IDLE; nxt_mode = RM_ARRAY; end
                        else bad = 1'b1;
                    end
                    S_BY_IDLE: begin
                        if (code == C_PGM)        nxt_state = S_BY_PGM;
                        else if (code == C_DPGM)  nxt_state = S_BY_DW1;
                        else if (code == C_IDENT) nxt_state = S_BY_EXIT;
                        else                      bad       = 1'b1;
                    end
                    S_BY_PGM: begin
                        if (busy) bad = 1'b1;
                        else begin act = ACT_PGM; nxt_state = S_BY_IDLE; end
                    end
                    S_BY_DW1: begin act = ACT_DW1; nxt_state = S_BY_DW2; end
                    S_BY_DW2: begin
                        if (busy) bad = 1'b1;
                        else begin act = ACT_DPGM; nxt_state = S_BY_IDLE; end
                    end
                    S_BY_EXIT: begin
                        if (code == C_BYEXIT) begin nxt_byp = 1'b0; nxt_mode = RM_ARRAY; nxt_state = S_IDLE; end
                        else bad = 1'b1;
                    end
                    default: bad = 1'b1;
                endcase
            end
            if (bad) begin
                act       = ACT_NONE;
                nxt_state = S_IDLE;
                nxt_mode  = RM_ARRAY;
                nxt_byp   = 1'b0;
            end
        end
    end

    // state, mode and bypass registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_mode  <= RM_ARRAY;
            bypass_on <= 1'b0;
        end else begin
            state     <= nxt_state;
            cur_mode  <= nxt_mode;
            bypass_on <= nxt_byp;
        end
    end

    assign mode = cur_mode;
endmodule

// File: rtl/fcd_outregs.sv
// Request and configuration registers: turns a completed action into a
// one-clock request pulse with captured operands, and holds the config word.
module fcd_outregs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] CFG_RESET = ADDR_W'('h8000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fcd_pkg::act_t     act,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              prog_req,
    output logic              prog_dual,
    output logic [ADDR_W-1:0] prog_addr_a,
    output logic [DATA_W-1:0] prog_data_a,
    output logic [ADDR_W-1:0] prog_addr_b,
    output logic [DATA_W-1:0] prog_data_b,
    output logic              erase_req,
    output logic              erase_bank,
    output logic [ADDR_W-1:0] erase_addr,
    output logic [ADDR_W-1:0] cfg_reg
);
    import fcd_pkg::*;

    logic [ADDR_W-1:0] first_addr;
    logic [DATA_W-1:0] first_data;

    // request pulses, operand capture and configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req    <= 1'b0;
            prog_dual   <= 1'b0;
            prog_addr_a <= '0;
            prog_data_a <= '0;
            prog_addr_b <= '0;
            prog_data_b <= '0;
            erase_req   <= 1'b0;
            erase_bank  <= 1'b0;
            erase_addr  <= '0;
            cfg_reg     <= CFG_RESET;
            first_addr  <= '0;
            first_data  <= '0;
        end else begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            case (act)
                ACT_PGM: begin
                    prog_req    <= 1'b1;
                    prog_dual   <= 1'b0;
                    prog_addr_a <= addr;
                    prog_data_a <= data;
                end
                ACT_DW1: begin
                    first_addr <= addr;
                    first_data <= data;
                end
                ACT_DPGM: begin
                    prog_req    <= 1'b1;
                    prog_dual   <= 1'b1;
                    prog_addr_a <= first_addr;
                    prog_data_a <= first_data;
                    prog_addr_b <= addr;
                    prog_data_b <= data;
                end
                ACT_ERB, ACT_ERK: begin
                    erase_req  <= 1'b1;
                    erase_bank <= (act == ACT_ERK);
                    erase_addr <= addr;
                end
                ACT_CFG: cfg_reg <= addr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fcd_top.sv
// Flash command sequence decoder top: classifier, sequencer and output
// registers. Assumes one write per wr_en strobe and a synchronous busy flag.
module fcd_top #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic [1:0]        mode,
    output logic              bypass_on,
    output logic              prog_req,
    output logic              prog_dual,
    output logic [ADDR_W-1:0] prog_addr_a,
    output logic [DATA_W-1:0] prog_data_a,
    output logic [ADDR_W-1:0] prog_addr_b,
    output logic [DATA_W-1:0] prog_data_b,
    output logic              erase_req,
    output logic              erase_bank,
    output logic [ADDR_W-1:0] erase_addr,
    output logic [ADDR_W-1:0] cfg_reg
);
    import fcd_pkg::*;

    logic  unl_a, unl_b, at_cmd, query_hit;
    act_t  act;

    fcd_classify #(.ADDR_W(ADDR_W)) u_cls (
        .addr(wr_addr), .code(wr_data[7:0]),
        .unl_a(unl_a), .unl_b(unl_b), .at_cmd(at_cmd), .query_hit(query_hit)
    );

    fcd_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
        .code(wr_data[7:0]), .unl_a(unl_a), .unl_b(unl_b),
        .at_cmd(at_cmd), .query_hit(query_hit),
        .act(act), .mode(mode), .bypass_on(bypass_on)
    );

    fcd_outregs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .act(act), .addr(wr_addr), .data(wr_data),
        .prog_req(prog_req), .prog_dual(prog_dual),
        .prog_addr_a(prog_addr_a), .prog_data_a(prog_data_a),
        .prog_addr_b(prog_addr_b), .prog_data_b(prog_data_b),
        .erase_req(erase_req), .erase_bank(erase_bank),
        .erase_addr(erase_addr), .cfg_reg(cfg_reg)
    );
endmodule

// File: rtl/fcd_checker.sv
// Cycle-level properties of the decoder's ports; attached by bind.
module fcd_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic [1:0]        mode,
    input logic              bypass_on,
    input logic              prog_req,
    input logic              erase_req,
    input logic [ADDR_W-1:0] cfg_reg
);
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req})); // R12
    AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R12
    AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req); // R12
    AST_REQ_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req) |-> $past(wr_en)); // R12
    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req) |-> !$past(busy)); // R11
    AST_BYP_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_on |-> (mode == 2'b00)); // R9
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(mode)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(cfg_reg)); // R8
endmodule

bind fcd_top fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .mode(mode),
    .bypass_on(bypass_on), .prog_req(prog_req), .erase_req(erase_req),
    .cfg_reg(cfg_reg)
);

// File: tb/sim_fcd_top.sv
module sim_fcd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic [1:0]  mode;
    logic        bypass_on, prog_req, prog_dual, erase_req, erase_bank;
    logic [15:0] prog_addr_a, prog_data_a, prog_addr_b, prog_data_b, erase_addr, cfg_reg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [1:0]  kind;   // 0 single, 1 dual, 2 block erase, 3 bank erase
        logic [15:0] a0, d0, a1, d1;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];

    always #4 clk = ~clk;

    fcd_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .mode(mode), .bypass_on(bypass_on), .prog_req(prog_req),
        .prog_dual(prog_dual), .prog_addr_a(prog_addr_a), .prog_data_a(prog_data_a),
        .prog_addr_b(prog_addr_b), .prog_data_b(prog_data_b), .erase_req(erase_req),
        .erase_bank(erase_bank), .erase_addr(erase_addr), .cfg_reg(cfg_reg)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
    endtask

    task automatic expect_req(input logic [1:0] k, input logic [15:0] a0, d0, a1, d1, input string tag);
        expq.push_back({k, a0, d0, a1, d1});
        tagq.push_back(tag);
    endtask

    // monitor: pops one expected request per observed pulse and compares
    bit prev_req = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prog_req || erase_req) begin
                if (prev_req) check(1'b0, "R12 pulse longer than one clock", 64'd1, 64'd0);
                if (expq.size() == 0) begin
                    check(1'b0, "R10 unexpected request", {62'd0, prog_req, erase_req}, 64'd0);
                end else begin
                    exp_t  e;
                    string t;
                    logic [63:0] got;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if (prog_req)
                        got = prog_dual ? {prog_addr_a, prog_data_a, prog_addr_b, prog_data_b}
                                        : {prog_addr_a, prog_data_a, e.a1, e.d1};
                    else
                        got = {erase_addr, e.d0, e.a1, e.d1};
                    check(((prog_req && e.kind == {1'b0, prog_dual}) ||
                           (erase_req && e.kind == {1'b1, erase_bank})) &&
                          got == {e.a0, e.d0, e.a1, e.d1},
                          t, got, {e.a0, e.d0, e.a1, e.d1});
                end
            end
            prev_req = prog_req || erase_req;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode == 2'b00 && !bypass_on && !prog_req && !erase_req, "R1 reset outputs",
              {mode, bypass_on, prog_req, erase_req}, 64'd0);
        check(cfg_reg == 16'h8000, "R1 reset cfg", cfg_reg, 64'h8000);

        // R2 single program
        expect_req(2'd0, 16'h1234, 16'hBEEF, 16'h0, 16'h0, "R2 program");
        unlock(); wr(16'h0555, 16'h00A0); wr(16'h1234, 16'hBEEF);

        // R3 double-word program
        expect_req(2'd1, 16'h0100, 16'h1111, 16'h0101, 16'h2222, "R3 dual program");
        unlock(); wr(16'h0555, 16'h0040); wr(16'h0100, 16'h1111); wr(16'h0101, 16'h2222);

        // R4 block and bank erase
        expect_req(2'd2, 16'h0040, 16'h0, 16'h0, 16'h0, "R4 block erase");
        unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h0040, 16'h0030);
        expect_req(2'd3, 16'h8000, 16'h0, 16'h0, 16'h0, "R4 bank erase");
        unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h8000, 16'h0010);

        // R6 query, R5 lone reset
        wr(16'h0055, 16'h0098);
        check(mode == 2'b10, "R6 query mode", mode, 64'd2);
        wr(16'h0000, 16'h00F0);
        check(mode == 2'b00, "R5 lone reset from query", mode, 64'd0);

        // R7 identification, R5 reset after unlock
        unlock(); wr(16'h0555, 16'h0090);
        check(mode == 2'b01, "R7 identification mode", mode, 64'd1);
        unlock(); wr(16'h0123, 16'h00F0);
        check(mode == 2'b00, "R5 unlocked reset", mode, 64'd0);

        // R5 reset ignored while busy
        wr(16'h0055, 16'h0098);
        busy = 1'b1;
        wr(16'h0000, 16'h00F0);
        check(mode == 2'b10, "R5 reset ignored when busy", mode, 64'd2);
        busy = 1'b0;
        wr(16'h0000, 16'h00F0);
        check(mode == 2'b00, "R5 reset after busy", mode, 64'd0);

        // R8 configuration load, R10 bad confirm leaves it
        unlock(); wr(16'h0555, 16'h0060); wr(16'h4A5C, 16'h0003);
        check(cfg_reg == 16'h4A5C, "R8 cfg load", cfg_reg, 64'h4A5C);
        wr(16'h0055, 16'h0098);
        unlock(); wr(16'h0555, 16'h0060); wr(16'h1111, 16'h0004);
        check(cfg_reg == 16'h4A5C, "R10 cfg untouched by bad confirm", cfg_reg, 64'h4A5C);
        check(mode == 2'b00, "R10 bad confirm to array", mode, 64'd0);

        // R9 bypass
        unlock(); wr(16'h0555, 16'h0020);
        check(bypass_on && mode == 2'b00, "R9 bypass entry", {mode, bypass_on}, 64'd1);
        expect_req(2'd0, 16'h2000, 16'hCAFE, 16'h0, 16'h0, "R9 bypass program");
        wr(16'h0000, 16'h00A0); wr(16'h2000, 16'hCAFE);
        expect_req(2'd1, 16'h3000, 16'h0A0A, 16'h3001, 16'h0B0B, "R9 bypass dual program");
        wr(16'h0000, 16'h0040); wr(16'h3000, 16'h0A0A); wr(16'h3001, 16'h0B0B);
        check(bypass_on, "R9 bypass held after programs", bypass_on, 64'd1);
        wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000);
        check(!bypass_on && mode == 2'b00, "R9 bypass exit", {mode, bypass_on}, 64'd0);

        // R10 invalid write in bypass
        unlock(); wr(16'h0555, 16'h0020);
        wr(16'h0000, 16'h0077);
        check(!bypass_on, "R10 bypass cleared by bad write", bypass_on, 64'd0);

        // R11 busy on completing write
        unlock(); wr(16'h0555, 16'h00A0);
        busy = 1'b1;
        wr(16'h4444, 16'h5555);
        busy = 1'b0;
        check(mode == 2'b00, "R11 busy completion to array", mode, 64'd0);
        wr(16'h0055, 16'h0098);
        unlock(); wr(16'h0555, 16'h0080); unlock();
        busy = 1'b1;
        wr(16'h0040, 16'h0030);
        busy = 1'b0;
        check(mode == 2'b00, "R11 busy erase confirm to array", mode, 64'd0);

        // R10 single-cycle corruption of erase and program sequences
        for (int i = 0; i < 6; i++) begin
            logic [15:0] ea [6];
            logic [15:0] ed [6];
            ea = '{16'h0555, 16'h02AA, 16'h0555, 16'h0555, 16'h02AA, 16'h0040};
            ed = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, 16'h0030};
            wr(16'h0055, 16'h0098);
            for (int j = 0; j < 6; j++) wr(ea[j], (j == i) ? (ed[j] ^ 16'h0001) : ed[j]);
            check(mode == 2'b00 && !bypass_on, "R10 corrupted erase", {mode, bypass_on}, 64'd0);
        end
        for (int i = 0; i < 3; i++) begin
            logic [15:0] pa [4];
            logic [15:0] pd [4];
            pa = '{16'h0555, 16'h02AA, 16'h0555, 16'h6000};
            pd = '{16'h00AA, 16'h0055, 16'h00A0, 16'h1234};
            wr(16'h0055, 16'h0098);
            for (int j = 0; j < 4; j++) wr(pa[j], (j == i) ? (pd[j] ^ 16'h0001) : pd[j]);
            check(mode == 2'b00, "R10 corrupted program", mode, 64'd0);
        end

        repeat (4) @(negedge clk);
        // R12 every expected request was seen exactly once
        check(expq.size() == 0, "R12 missing requests", expq.size(), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule